// File: doc/BRIEF.md
# Panning Framebuffer Fetch Engine

This block reads the visible part of a larger virtual framebuffer out of memory and stages it, word by word, in a pixel FIFO that a display pipeline drains. Software describes the window with four values: a starting byte address, the number of 32-bit words in one visible line, the number of bytes to jump over at the end of each visible line, and the total number of words in a frame. A fifth value, the bit position of the first pixel inside the first word, is carried alongside and presented to the pixel stage.

Reads go out as fixed-length bursts of single-word requests on a plain request/grant interface. Data comes back in order on a valid strobe. A new burst is launched only while the words already stored plus the words still owed by memory stay below a margin under the FIFO depth, so the block's own fetches can never overfill it. When software loads new window settings while the engine runs, they are held back. They take over when the last word of the current frame has been requested, so a frame is never split between two settings. Three sticky flags record FIFO underflow, FIFO overwrite and memory read error. Each flag has its own enable and a write-one-to-clear input.

Top module: `fb_window_fetch`

## Requirements
- R1: After reset, no request is issued, `busy` is low, `flags` is 000, `pix_valid` is low and `irq` is low.
- R2: Inside a visible line, successive requested words have byte addresses 4 apart, and the first word of a frame is at the committed base with its two low bits forced to zero.
- R3: After the last word of a visible line (`line_words` words), the next address is the previous address plus 4 plus `skip_bytes`, with the two low bits forced to zero.
- R4: After `frame_words` words have been requested, the next address is the committed base again and the line position restarts, even if the frame ends partway through a line.
- R5: Requests come in bursts of `BURST` words. A request that is not granted keeps the same address on the next cycle, and a burst that has started is always finished.
- R6: A burst starts only while `enable` is high, no burst is active, and FIFO occupancy plus outstanding responses is below `DEPTH - (2*BURST + 3)`.
- R7: A `cfg_update` pulse while the engine is idle makes the new settings current at once. While the engine is busy, the settings are held pending and become current when the last word of the frame is requested, or when the engine goes idle. `pix_off` shows the current 5-bit pixel bit offset.
- R8: A pop while the FIFO is empty returns zero on `pix_data` and sets `flags[0]` (underflow).
- R9: A response word that arrives while the FIFO holds `DEPTH` words is dropped, the stored words are not changed, and `flags[1]` (overwrite) is set.
- R10: A response with `mem_rerr` high sets `flags[2]`, and the word is still stored in order.
- R11: Flags stay set until a 1 is written to the matching `flag_clr` bit; a new event in the same cycle wins over the clear. `irq` is the OR of the flags masked by `flag_en`.
- R12: `busy` is high while `enable` is high, a burst is active, or responses are still owed. Dropping `enable` lets the current burst and its responses complete before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new bursts to start |
| cfg_update | input | 1 | Pulse: capture the cfg_* values |
| cfg_base | input | AW | Window start byte address |
| cfg_pix_off | input | 5 | Bit offset of the first pixel in the first word |
| cfg_line_words | input | LINE_W | Words per visible line |
| cfg_skip_bytes | input | LINE_W | Bytes skipped after each visible line |
| cfg_frame_words | input | FRAME_W | Words per frame |
| busy | output | 1 | Engine active or draining |
| pix_off | output | 5 | Current pixel bit offset |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | AW | Read byte address (word aligned) |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response word valid |
| mem_rdata | input | 32 | Response word |
| mem_rerr | input | 1 | Response carries an error |
| pop | input | 1 | Consumer takes the head word |
| pix_valid | output | 1 | FIFO not empty |
| pix_data | output | 32 | Head word, zero when empty |
| flag_en | input | 3 | Per-flag interrupt enable |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| flags | output | 3 | {error, overwrite, underflow} |
| irq | output | 1 | Any enabled flag set |

## Verification
The bench builds the engine with `DEPTH=32` and `BURST=4`, which gives a start threshold of 21 words. With these values the FIFO can be filled to its exact steady level of 24 words, and to full, within a few dozen cycles, so the threshold edge and the overwrite case can both be reached directly. The memory model grants on a rotating pattern with stalls, so the window walks through line skips, frame wraps in mid-line and a deferred settings change all run with stalled requests.

// File: rtl/fb_window_fetch.sv
module fb_window_fetch #(
  parameter int AW      = 32,
  parameter int DEPTH   = 512,
  parameter int BURST   = 8,
  parameter int LINE_W  = 16,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cfg_update,
  input  logic [AW-1:0]      cfg_base,
  input  logic [4:0]         cfg_pix_off,
  input  logic [LINE_W-1:0]  cfg_line_words,
  input  logic [LINE_W-1:0]  cfg_skip_bytes,
  input  logic [FRAME_W-1:0] cfg_frame_words,
  output logic               busy,
  output logic [4:0]         pix_off,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_rerr,
  input  logic               pop,
  output logic               pix_valid,
  output logic [31:0]        pix_data,
  input  logic [2:0]         flag_en,
  input  logic [2:0]         flag_clr,
  output logic [2:0]         flags,
  output logic               irq
);
  localparam int PW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int BW     = $clog2(BURST + 1);
  localparam int THRESH = DEPTH - (2 * BURST + 3);
  localparam logic [AW-1:0]      WMASK = ~AW'(3);
  localparam logic [LINE_W-1:0]  L1    = LINE_W'(1);
  localparam logic [FRAME_W-1:0] F1    = FRAME_W'(1);
  localparam logic [CW:0]        THR   = (CW+1)'(THRESH);

  logic [AW-1:0]      a_base, p_base, addr, jump;
  logic [4:0]         a_po, p_po;
  logic [LINE_W-1:0]  a_lw, p_lw, a_skip, p_skip, lcnt;
  logic [FRAME_W-1:0] a_fw, p_fw, fcnt;
  logic               p_valid, grant, line_end, frame_end, start, full, push, take, ret;
  logic [BW-1:0]      left;
  logic [CW-1:0]      inflight, cnt;
  logic [CW:0]        reserve;
  logic [PW-1:0]      wp, rp;
  logic [31:0]        ram [DEPTH];
  logic [2:0]         fl_q, fl_set;

  assign mem_req   = left != '0;
  assign mem_addr  = addr;
  assign grant     = mem_req & mem_gnt;
  assign busy      = enable | mem_req | (inflight != '0);
  assign pix_off   = a_po;
  assign line_end  = (a_lw == '0) || (lcnt == a_lw - L1);
  assign frame_end = (a_fw == '0) || (fcnt == a_fw - F1);
  assign jump      = addr + AW'(4) + AW'(a_skip);
  assign reserve   = {1'b0, cnt} + {1'b0, inflight};
  assign start     = enable && !mem_req && (reserve < THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_base <= '0; a_po <= '0; a_lw <= '0; a_skip <= '0; a_fw <= '0;
      p_base <= '0; p_po <= '0; p_lw <= '0; p_skip <= '0; p_fw <= '0;
      p_valid <= 1'b0; addr <= '0; lcnt <= '0; fcnt <= '0;
    end else begin
      if (!busy || (grant && frame_end)) begin
        lcnt <= '0;
        fcnt <= '0;
        if (p_valid) begin
          a_base <= p_base; a_po <= p_po; a_lw <= p_lw; a_skip <= p_skip; a_fw <= p_fw;
          addr <= p_base & WMASK;
          p_valid <= 1'b0;
        end else begin
          addr <= a_base & WMASK;
        end
      end else if (grant) begin
        fcnt <= fcnt + F1;
        if (line_end) begin
          lcnt <= '0;
          addr <= jump & WMASK;
        end else begin
          lcnt <= lcnt + L1;
          addr <= addr + AW'(4);
        end
      end
      if (cfg_update) begin
        if (!busy) begin
          a_base <= cfg_base; a_po <= cfg_pix_off; a_lw <= cfg_line_words;
          a_skip <= cfg_skip_bytes; a_fw <= cfg_frame_words;
          addr <= cfg_base & WMASK;
          p_valid <= 1'b0;
        end else begin
          p_base <= cfg_base; p_po <= cfg_pix_off; p_lw <= cfg_line_words;
          p_skip <= cfg_skip_bytes; p_fw <= cfg_frame_words;
          p_valid <= 1'b1;
        end
      end
    end
  end

  assign ret = mem_rvalid && (inflight != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left     <= '0;
      inflight <= '0;
    end else begin
      if (start)      left <= BW'(BURST);
      else if (grant) left <= left - BW'(1);
      case ({grant, ret})
        2'b10:   inflight <= inflight + CW'(1);
        2'b01:   inflight <= inflight - CW'(1);
        default: inflight <= inflight;
      endcase
    end
  end

  assign full      = cnt == CW'(DEPTH);
  assign push      = mem_rvalid && !full;
  assign pix_valid = cnt != '0;
  assign take      = pop && pix_valid;
  assign pix_data  = pix_valid ? ram[rp] : 32'h0;

  always_ff @(posedge clk) if (push) ram[wp] <= mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (take) rp <= rp + PW'(1);
      case ({push, take})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign fl_set = {mem_rvalid & mem_rerr, mem_rvalid & full, pop & ~pix_valid};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= (fl_q & ~flag_clr) | fl_set;
  end
  assign flags = fl_q;
  assign irq   = |(fl_q & flag_en);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R5
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    reserve <= (CW+1)'(DEPTH)); // R6
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(enable)); // R6
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !pix_valid |=> flags[0]); // R8
  AST_BUSY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(mem_req)); // R12
endmodule

// File: tb/sim_fb_window_fetch.sv
module sim_fb_window_fetch;
  localparam int DEPTH = 32;
  localparam int BURST = 4;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] lw;
    logic [15:0] skip;
    logic [23:0] fw;
    logic [4:0]  po;
  } vec_t;

  localparam vec_t VT [4] = '{
    '{32'h0000_1000, 16'd4, 16'd8,  24'd12, 5'd0},
    '{32'h0000_2003, 16'd3, 16'd6,  24'd9,  5'd12},
    '{32'h0000_0040, 16'd1, 16'd0,  24'd5,  5'd31},
    '{32'h0000_8000, 16'd5, 16'd20, 24'd7,  5'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfg_update = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_pix_off = '0;
  logic [15:0] cfg_line_words = '0, cfg_skip_bytes = '0;
  logic [23:0] cfg_frame_words = '0;
  logic busy, mem_req, mem_gnt, mem_rvalid, mem_rerr, pix_valid, irq;
  logic [4:0]  pix_off;
  logic [31:0] mem_addr, mem_rdata, pix_data;
  logic pop = 1'b0;
  logic [2:0] flag_en = '0, flag_clr = '0, flags;

  logic rv_q, re_q, inj = 1'b0, err_on = 1'b0, gnt_all = 1'b0;
  logic [31:0] rd_q, inj_d = '0, err_addr = '0;
  logic [3:0] gpat = 4'b1001;
  int grants = 0, checks = 0, errors = 0;

  always #5 clk = ~clk;

  fb_window_fetch #(.DEPTH(DEPTH), .BURST(BURST)) u0 (
    .clk, .rst_n, .enable, .cfg_update, .cfg_base, .cfg_pix_off, .cfg_line_words,
    .cfg_skip_bytes, .cfg_frame_words, .busy, .pix_off, .mem_req, .mem_addr, .mem_gnt,
    .mem_rvalid, .mem_rdata, .mem_rerr, .pop, .pix_valid, .pix_data, .flag_en,
    .flag_clr, .flags, .irq);

  always @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0; re_q <= 1'b0; rd_q <= '0;
    end else begin
      rv_q <= mem_req && mem_gnt;
      rd_q <= mem_addr;
      re_q <= err_on && mem_req && mem_gnt && (mem_addr == err_addr);
    end
    if (rst_n && mem_req && mem_gnt) grants <= grants + 1;
  end
  always @(negedge clk) gpat <= {gpat[2:0], gpat[3] ^ gpat[2]};
  assign mem_gnt    = gnt_all | gpat[0];
  assign mem_rvalid = rv_q | inj;
  assign mem_rdata  = inj ? inj_d : rd_q;
  assign mem_rerr   = re_q;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_idle(input vec_t v);
    @(negedge clk);
    cfg_base = v.base; cfg_pix_off = v.po; cfg_line_words = v.lw;
    cfg_skip_bytes = v.skip; cfg_frame_words = v.fw; cfg_update = 1'b1;
    @(negedge clk);
    cfg_update = 1'b0;
    chk(pix_off == v.po, "R7 idle commit", 32'(pix_off), 32'(v.po));
  endtask

  task automatic run_seq(input vec_t v, input int n, input bit do_upd, input vec_t nv, input int upd_at);
    vec_t cur = v;
    bit pend = 1'b0, sent = 1'b0;
    logic [31:0] a = v.base & ~32'h3;
    int r = 0, c = 0, got = 0;
    string lab = "R2 frame start";
    while (got < n) begin
      @(negedge clk);
      cfg_update = 1'b0;
      pop = 1'b0;
      if (do_upd && !sent && got == upd_at) begin
        cfg_base = nv.base; cfg_pix_off = nv.po; cfg_line_words = nv.lw;
        cfg_skip_bytes = nv.skip; cfg_frame_words = nv.fw; cfg_update = 1'b1;
        sent = 1'b1; pend = 1'b1;
      end
      if (pix_valid) begin
        chk(pix_data == a, lab, pix_data, a);
        pop = 1'b1;
        got++;
        r++; c++;
        if (r >= int'(cur.fw)) begin
          r = 0; c = 0;
          if (pend) begin cur = nv; pend = 1'b0; lab = "R7 deferred commit"; end
          else lab = "R4 frame wrap";
          a = cur.base & ~32'h3;
        end else if (c >= int'(cur.lw)) begin
          c = 0;
          a = (a + 32'd4 + 32'(cur.skip)) & ~32'h3;
          lab = "R3 line skip";
        end else begin
          a = a + 32'd4;
          lab = "R2 in line";
        end
      end
    end
    @(negedge clk);
    pop = 1'b0;
    cfg_update = 1'b0;
  endtask

  task automatic stop_drain(output int drained);
    drained = 0;
    @(negedge clk);
    enable = 1'b0;
    while (busy) @(negedge clk);
    while (pix_valid) begin
      pop = 1'b1;
      drained++;
      @(negedge clk);
    end
    pop = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pop = 1'b1;
    end
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d, g0;
    vec_t va, vb, vt;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R1 req", 32'(mem_req), 0);
    chk(!busy, "R1 busy", 32'(busy), 0);
    chk(flags == 3'b000, "R1 flags", 32'(flags), 0);
    chk(!pix_valid && !irq, "R1 valid/irq", {30'd0, pix_valid, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      apply_idle(VT[i]);
      enable = 1'b1;
      run_seq(VT[i], 2 * int'(VT[i].fw) + 3, 1'b0, VT[i], 0);
      stop_drain(d);
    end

    va = '{32'h0001_0000, 16'd4, 16'd16, 24'd40, 5'd3};
    vb = '{32'h0002_0000, 16'd2, 16'd4,  24'd6,  5'd9};
    apply_idle(va);
    enable = 1'b1;
    run_seq(va, 50, 1'b1, vb, 2);
    chk(pix_off == vb.po, "R7 offset after commit", 32'(pix_off), 32'(vb.po));
    stop_drain(d);

    gnt_all = 1'b1;
    vt = '{32'h0003_0000, 16'd8, 16'd0, 24'd1000, 5'd0};
    apply_idle(vt);
    g0 = grants;
    enable = 1'b1;
    repeat (60) @(negedge clk);
    chk(grants - g0 == 24, "R6 fill level", 32'(grants - g0), 24);
    chk(busy, "R12 busy while enabled", 32'(busy), 1);
    pop_n(3);
    repeat (30) @(negedge clk);
    chk(grants - g0 == 24, "R6 no start at threshold", 32'(grants - g0), 24);
    pop_n(1);
    repeat (30) @(negedge clk);
    chk(grants - g0 == 28, "R6 start below threshold", 32'(grants - g0), 28);
    stop_drain(d);

    gnt_all = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    while (!mem_req) @(negedge clk);
    g0 = grants;
    enable = 1'b0;
    @(negedge clk);
    chk(busy, "R12 busy after disable", 32'(busy), 1);
    while (busy) @(negedge clk);
    chk(grants - g0 == BURST, "R5 burst completes", 32'(grants - g0), BURST);
    stop_drain(d);
    chk(d == BURST, "R12 drained words", 32'(d), BURST);

    @(negedge clk);
    pop = 1'b1;
    #1 chk(pix_data == 32'h0, "R8 zero data", pix_data, 0);
    @(negedge clk);
    pop = 1'b0;
    chk(flags[0], "R8 underflow flag", 32'(flags), 1);
    chk(!irq, "R11 masked irq", 32'(irq), 0);
    flag_en = 3'b001;
    #1 chk(irq, "R11 enabled irq", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk(flags[0], "R11 sticky", 32'(flags), 1);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    chk(flags == 3'b000 && !irq, "R11 clear", {28'd0, flags, irq}, 0);

    for (int k = 0; k <= DEPTH; k++) begin
      @(negedge clk);
      inj = 1'b1;
      inj_d = (k == DEPTH) ? 32'hBEEF : 32'hA000 + 32'(k);
    end
    @(negedge clk);
    inj = 1'b0;
    chk(flags[1], "R9 overwrite flag", 32'(flags), 2);
    chk(pix_data == 32'hA000, "R9 head kept", pix_data, 32'hA000);
    stop_drain(d);
    chk(d == DEPTH, "R9 word dropped", 32'(d), DEPTH);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;

    err_on = 1'b1;
    err_addr = 32'h0005_0004;
    vt = '{32'h0005_0000, 16'd4, 16'd0, 24'd8, 5'd0};
    apply_idle(vt);
    enable = 1'b1;
    run_seq(vt, 4, 1'b0, vt, 0);
    chk(flags[2], "R10 error flag", 32'(flags), 4);
    chk(flags[1:0] == 2'b00, "R10 other flags", 32'(flags), 4);
    stop_drain(d);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule